// File: doc/BRIEF.md
# Event Timer Global Control and Interrupt Routing

This block is the shared part of a three-channel event timer. It owns a free-running 64-bit main counter, a read-only capability word and a small configuration register. The configuration register has two bits. One is a master enable. The other selects legacy routing. Each timer channel has a 64-bit comparator, a routing field and a level/edge mode bit. When the running counter reaches a channel's comparator value, the channel latches a status bit and raises its request. The block then steers every request onto one of two output banks: a 16-line bank for a legacy PIC and a 24-line bank for an APIC.

Software reaches everything through a plain register port. A write happens on a clock edge when `acc_wr` is high. Read data is a combinational function of `acc_addr`. Clearing the master enable has three effects:
- the counter freezes;
- every interrupt output goes quiet;
- latched status is kept until software clears it.

Legacy routing pins channels 0 and 1 to fixed lines. Channel 2 always follows its own routing field.

Top module: `evt_timer_global`

## Requirements
- R1: The main counter (read/write at offset 0F0h) increases by exactly one on every clock edge while the master enable is 1, and keeps its value while the enable is 0. It resets to 0.
- R2: While the master enable is 0, every bit of `pic_irq` and `apic_irq` is 0, whatever the status or routing.
- R3: Status bits sit at offset 020h, with bit n for channel n.
  - A channel's status bit sets on the edge after the enabled counter equals that channel's comparator.
  - Status survives clearing the master enable.
  - Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
  - A new match wins over a clear in the same cycle.
- R4: With enable and legacy bits both 1, channel 0 drives `pic_irq[0]` and `apic_irq[2]`, and channel 1 drives `pic_irq[8]` and `apic_irq[8]`. The routing fields of channels 0 and 1 are then ignored.
- R5: Channel 2 always uses its own routing field. With the legacy bit 0, channels 0 and 1 also use their own fields. In that case `pic_irq` stays all 0.
- R6: A routing field value of 24 or more drives no output line.
- R7: The configuration register is at offset 010h.
  - Bit 0 is the master enable and bit 1 is legacy routing.
  - Both bits reset to 0.
  - All other bits read 0, whatever was written to them.
- R8: Offset 000h reads the constant 0429B17F8086A201h. This holds a tick period of 0429B17Fh fs, vendor 8086h, counter-size bit 15 set, legacy-capable bit 13 set, channel count minus one (02h) in bits 12:8 and revision 01h.
- R9: A write to the main counter takes effect only while the master enable is 0. A write made while the counter runs is ignored.
- R10: Channel n has two registers.
  - Its configuration is at 100h+20h*n, with the routing field in bits 4:0 and level mode in bit 8.
  - Its comparator is at 108h+20h*n.
  - In level mode the request follows the status bit.
  - In edge mode the request is a single-cycle pulse, one cycle after the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 12 | Register byte offset |
| acc_wdata | input | 64 | Register write data |
| acc_rdata | output | 64 | Register read data, combinational from `acc_addr` |
| pic_irq | output | 16 | Legacy PIC interrupt lines |
| apic_irq | output | 24 | APIC interrupt lines |

## Verification
A vector table fires one channel at a time. Each entry sets a channel number, a legacy bit and a routing field, and the bench checks both output banks and the status word.

The entries separate three cases: fixed legacy lines with a conflicting routing field, the same field with legacy mode off, and channel 2 staying on its field under legacy mode. Routing values 24 and 31 check that out-of-range fields are dropped.

Directed tests cover the rest:
- counter stepping and holding;
- writes to the running counter;
- status retention through a disable, and write-0 versus write-1 clearing;
- edge mode, checked by counting exactly one pulse.

// File: rtl/evt_timer_global.sv
module evt_timer_global #(
  parameter int          NTIMERS    = 3,
  parameter int          CNT_W      = 64,
  parameter int          APIC_LINES = 24,
  parameter int          PIC_LINES  = 16,
  parameter int          AW         = 12,
  parameter logic [31:0] TICK_FS    = 32'h0429B17F,
  parameter logic [15:0] VENDOR     = 16'h8086,
  parameter logic [7:0]  REV        = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_wr,
  input  logic [AW-1:0]         acc_addr,
  input  logic [63:0]           acc_wdata,
  output logic [63:0]           acc_rdata,
  output logic [PIC_LINES-1:0]  pic_irq,
  output logic [APIC_LINES-1:0] apic_irq
);
  localparam logic [63:0] CAP = {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1, 5'(NTIMERS - 1), REV};
  localparam logic [AW-1:0] A_CAP = AW'(12'h000);
  localparam logic [AW-1:0] A_CFG = AW'(12'h010);
  localparam logic [AW-1:0] A_STS = AW'(12'h020);
  localparam logic [AW-1:0] A_CNT = AW'(12'h0F0);

  logic               en, leg;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cmp   [NTIMERS];
  logic [4:0]         route [NTIMERS];
  logic [NTIMERS-1:0] lvl, sts, pulse, hit, req, wr_tcfg, wr_tcmp;

  wire wr_cfg = acc_wr && acc_addr == A_CFG;
  wire wr_sts = acc_wr && acc_addr == A_STS;
  wire wr_cnt = acc_wr && acc_addr == A_CNT;

  always_comb begin
    for (int n = 0; n < NTIMERS; n++) begin
      wr_tcfg[n] = acc_wr && acc_addr == AW'(256 + 32 * n);
      wr_tcmp[n] = acc_wr && acc_addr == AW'(264 + 32 * n);
      hit[n]     = en && cnt == cmp[n];
      req[n]     = en && (lvl[n] ? sts[n] : pulse[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      leg   <= 1'b0;
      cnt   <= '0;
      sts   <= '0;
      pulse <= '0;
      lvl   <= '0;
      for (int n = 0; n < NTIMERS; n++) begin
        cmp[n]   <= '1;
        route[n] <= '1;
      end
    end else begin
      if (wr_cfg) {leg, en} <= acc_wdata[1:0];
      if (en) cnt <= cnt + 1'b1;
      else if (wr_cnt) cnt <= acc_wdata[CNT_W-1:0];
      sts   <= (sts & ~(wr_sts ? acc_wdata[NTIMERS-1:0] : '0)) | hit;
      pulse <= hit;
      for (int n = 0; n < NTIMERS; n++) begin
        if (wr_tcfg[n]) begin
          lvl[n]   <= acc_wdata[8];
          route[n] <= acc_wdata[4:0];
        end
        if (wr_tcmp[n]) cmp[n] <= acc_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    pic_irq  = '0;
    apic_irq = '0;
    for (int n = 0; n < NTIMERS; n++) begin
      if (leg && n == 0) begin
        pic_irq[0]  = pic_irq[0]  | req[n];
        apic_irq[2] = apic_irq[2] | req[n];
      end else if (leg && n == 1) begin
        pic_irq[8]  = pic_irq[8]  | req[n];
        apic_irq[8] = apic_irq[8] | req[n];
      end else if (32'(route[n]) < APIC_LINES) begin
        apic_irq[route[n]] = apic_irq[route[n]] | req[n];
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    case (acc_addr)
      A_CAP:   acc_rdata = CAP;
      A_CFG:   acc_rdata = {62'd0, leg, en};
      A_STS:   acc_rdata = 64'(sts);
      A_CNT:   acc_rdata = 64'(cnt);
      default: ;
    endcase
    for (int n = 0; n < NTIMERS; n++) begin
      if (acc_addr == AW'(256 + 32 * n)) acc_rdata = 64'({lvl[n], 3'b000, route[n]});
      if (acc_addr == AW'(264 + 32 * n)) acc_rdata = 64'(cmp[n]);
    end
  end

  p_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> cnt == $past(cnt) + 1'b1);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_cnt) |=> cnt == $past(cnt));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && wr_cnt) |=> cnt == $past(acc_wdata[CNT_W-1:0]));
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pic_irq == '0 && apic_irq == '0));
  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> (sts & $past(sts)) == $past(sts));
  p_nopic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !leg |-> pic_irq == '0);
  p_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && leg) |-> $countones(pic_irq) <= 2);
endmodule

// File: tb/evt_timer_global_bench.sv
module evt_timer_global_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  logic [15:0] pic_irq;
  logic [23:0] apic_irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  evt_timer_global u_evt_timer_global (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .pic_irq(pic_irq), .apic_irq(apic_irq));

  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  t;
    logic        leg;
    logic [4:0]  rt;
    logic [23:0] apic;
    logic [15:0] pic;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b1, 5'd5,  24'h000004, 16'h0001},
    '{2'd1, 1'b1, 5'd3,  24'h000100, 16'h0100},
    '{2'd2, 1'b1, 5'd7,  24'h000080, 16'h0000},
    '{2'd0, 1'b0, 5'd5,  24'h000020, 16'h0000},
    '{2'd1, 1'b0, 5'd23, 24'h800000, 16'h0000},
    '{2'd2, 1'b0, 5'd0,  24'h000001, 16'h0000},
    '{2'd0, 1'b0, 5'd24, 24'h000000, 16'h0000},
    '{2'd2, 1'b1, 5'd31, 24'h000000, 16'h0000}
  };

  localparam logic [11:0] A_CAP = 12'h000, A_CFG = 12'h010, A_STS = 12'h020, A_CNT = 12'h0F0;

  function automatic logic [11:0] a_tcfg(int n); return 12'(256 + 32 * n); endfunction
  function automatic logic [11:0] a_tcmp(int n); return 12'(264 + 32 * n); endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] d);
    acc_addr = a;
    #1;
    d = acc_rdata;
  endtask

  task automatic fire(int t, logic leg, logic [4:0] rt, logic level);
    wr(A_CFG, 64'd0);
    wr(A_STS, 64'h7);
    wr(A_CNT, 64'd0);
    for (int k = 0; k < 3; k++) wr(a_tcmp(k), 64'hFFFF_FFFF_0000_0000);
    wr(a_tcfg(t), {55'd0, level, 3'b000, rt});
    wr(a_tcmp(t), 64'd4);
    wr(A_CFG, {62'd0, leg, 1'b1});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, c0;
    int np;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(A_CFG, d); chk("R7 cfg reset", d, 64'd0);
    rd(A_CAP, d); chk("R8 capability", d, 64'h0429B17F8086A201);
    chk("R2 outputs after reset", {24'd0, pic_irq, apic_irq}, 64'd0);
    rd(A_CNT, d); chk("R1 counter reset", d, 64'd0);
    repeat (5) @(negedge clk);
    rd(A_CNT, d); chk("R1 counter holds while disabled", d, 64'd0);
    wr(A_CFG, 64'hFFFF_FFFF_FFFF_FFFC);
    rd(A_CFG, d); chk("R7 other cfg bits read 0", d, 64'd0);

    for (int i = 0; i < 8; i++) begin
      fire(VEC[i].t, VEC[i].leg, VEC[i].rt, 1'b1);
      repeat (10) @(negedge clk);
      chk($sformatf("R4/R5/R6 apic vec %0d", i), 64'(apic_irq), 64'(VEC[i].apic));
      chk($sformatf("R4/R5 pic vec %0d", i), 64'(pic_irq), 64'(VEC[i].pic));
      rd(A_STS, d); chk($sformatf("R3 status set vec %0d", i), d, 64'(1 << VEC[i].t));
      wr(A_CFG, 64'd0);
      chk($sformatf("R2 quiet after disable vec %0d", i), {24'd0, pic_irq, apic_irq}, 64'd0);
      rd(A_STS, d); chk($sformatf("R3 status retained vec %0d", i), d, 64'(1 << VEC[i].t));
      wr(A_STS, 64'd0);
      rd(A_STS, d); chk($sformatf("R3 write 0 keeps vec %0d", i), d, 64'(1 << VEC[i].t));
      wr(A_STS, 64'(1 << VEC[i].t));
      rd(A_STS, d); chk($sformatf("R3 write 1 clears vec %0d", i), d, 64'd0);
    end

    wr(A_CNT, 64'd100);
    rd(A_CNT, d); chk("R9 load while disabled", d, 64'd100);
    wr(A_CFG, 64'd1);
    rd(A_CNT, c0);
    repeat (7) @(negedge clk);
    rd(A_CNT, d); chk("R1 counter steps by one per cycle", d, c0 + 64'd7);
    rd(A_CNT, c0);
    wr(A_CNT, 64'd5);
    rd(A_CNT, d); chk("R9 write while running ignored", d, c0 + 64'd2);
    wr(A_CFG, 64'd0);
    rd(A_CNT, c0);
    repeat (6) @(negedge clk);
    rd(A_CNT, d); chk("R1 counter frozen after disable", d, c0);

    fire(1, 1'b0, 5'd9, 1'b0);
    np = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (apic_irq[9]) np++;
    end
    chk("R10 edge mode single pulse", 64'(np), 64'd1);
    rd(A_STS, d); chk("R3 edge match sets status", d, 64'h2);
    rd(a_tcfg(1), d); chk("R10 channel cfg readback", d, 64'h009);
    wr(a_tcfg(1), 64'h109);
    @(negedge clk);
    chk("R10 level mode follows status", 64'(apic_irq), 64'h000200);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule